// File: doc/BRIEF.md
# Sequential Floating-Point Multiplier

This unit multiplies two floating-point operands that share one 24-bit word layout: the sign is bit 23, an 8-bit exponent biased by 127 is bits 22:15, and a 15-bit fraction is bits 14:0. The fraction has an implied leading one. An exponent field of zero marks the value zero. No other special values or denormals exist. A caller presents both operands and pulses `start` while `busy` is low. It then waits for the one-cycle `done` pulse, which comes with the product and the two range flags.

The 16-bit significands are multiplied as unsigned magnitudes. The multiply takes one step per multiplier bit: each step conditionally adds the multiplicand into a 32-bit accumulator, which then shifts right. The sign is formed as the XOR of the operand signs. The exponent is the sum of the operand exponents with the bias taken out once. After the multiply, the product is normalized and then rounded, and its exponent is checked against the representable range.

The controller has five states:
- S_IDLE waits for `start`. When `start` arrives it goes to S_DONE if an operand is zero, otherwise to S_MUL.
- S_MUL repeats for 16 cycles and then goes to S_NORM.
- S_NORM goes to S_RND.
- S_RND goes to S_DONE.
- S_DONE always goes back to S_IDLE.

Top module: `fp_seq_mul`

## Requirements
- R1: Operand and result words use sign at bit 23, a biased exponent (bias 127) at bits 22:15 and a fraction at bits 14:0 with a hidden leading one. An exponent field of 0 means zero.
- R2: If either operand has exponent field 0, the product is 24'h000000 with both flags low. `done` is high in the cycle right after the accepting edge.
- R3: For a nonzero, in-range result, product bit 23 equals the XOR of the two operand sign bits.
- R4: The result exponent field equals ea + eb - 127, plus any increments from R5 and R7.
- R5: If the significand product is 2.0 or more, it is shifted right one place and the exponent is incremented.
- R6: Rounding is half-up on the first bit below the 15 kept fraction bits.
- R7: If rounding overflows the significand, the significand becomes 1.0 and the exponent is incremented again.
- R8: If the final exponent exceeds 255, `overflow` is 1. The product then keeps the computed sign and has all exponent and fraction bits set.
- R9: If the final exponent is below 1, `underflow` is 1 and the product is 24'h000000.
- R10: For nonzero operands, `done` is high in the cycle that follows the 18th clock edge after the accepting edge. `busy` is high from the accepting edge through the `done` cycle.
- R11: `done` lasts one cycle. A `start` while `busy` is high is ignored and does not disturb the operation in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiply (taken only when not busy) |
| op_a | input | 24 | Multiplicand word |
| op_b | input | 24 | Multiplier word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| product | output | 24 | Result word |
| overflow | output | 1 | Result exponent above range |
| underflow | output | 1 | Result exponent below range, flushed to zero |

## Verification
The bench targets the products on either side of 2.0. If the normalize shift were missing, 1.5 x 1.5 would come out with a wrong exponent and fraction.

It uses an operand pair whose rounded significand carries out to 2.0. If the renormalize step were dropped, that case would return 1.0 with an exponent one too small.

It places exponent sums exactly at and just past both range limits. An off-by-one in the range compare would set a flag one step early or late.

It sends zero operands of either sign, which must bypass the multiply and finish at once. It also pulses `start` in the middle of an operation; a design that accepted it would corrupt the pending result or its timing.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_MUL,
        S_NORM,
        S_RND,
        S_DONE
    } fpm_state_e;
endpackage

// File: rtl/fpm_sig_mul.sv
// Iterative unsigned significand multiplier: one add-and-shift step per cycle.
module fpm_sig_mul #(
    parameter int SIG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [SIG_W-1:0]   mcand,
    input  logic [SIG_W-1:0]   mplier,
    output logic [SIG_W+1:0]   prod_hi
);
    localparam int PW = 2 * SIG_W;

    logic [PW-1:0]  acc;
    logic [SIG_W:0] sum;

    // Upper half plus the multiplicand when the current multiplier bit is set.
    always_comb begin
        sum = {1'b0, acc[PW-1:SIG_W]} + (acc[0] ? {1'b0, mcand} : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (load) begin
            acc <= {{SIG_W{1'b0}}, mplier};
        end else if (step) begin
            acc <= {sum, acc[SIG_W-1:1]};
        end
    end

    assign prod_hi = acc[PW-1 -: SIG_W+2];
endmodule

// File: rtl/fpm_normalize.sv
// Picks the kept fraction and the round bit depending on the product's top bit.
module fpm_normalize #(
    parameter int SIG_W = 16,
    parameter int EW    = 10
) (
    input  logic [SIG_W+1:0]       prod_hi,
    input  logic signed [EW-1:0]   exp_in,
    output logic [SIG_W-2:0]       frac,
    output logic                   rnd,
    output logic signed [EW-1:0]   exp_out
);
    always_comb begin
        if (prod_hi[SIG_W+1]) begin
            frac    = prod_hi[SIG_W:2];
            rnd     = prod_hi[1];
            exp_out = exp_in + EW'(1);
        end else begin
            frac    = prod_hi[SIG_W-1:1];
            rnd     = prod_hi[0];
            exp_out = exp_in;
        end
    end
endmodule

// File: rtl/fpm_round_pack.sv
// Half-up rounding, carry renormalization, range check and word assembly.
module fpm_round_pack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 15,
    parameter int EW     = EXP_W + 2
) (
    input  logic                     sign,
    input  logic [FRAC_W-1:0]        frac_in,
    input  logic                     rnd,
    input  logic signed [EW-1:0]     exp_in,
    output logic [EXP_W+FRAC_W:0]    word,
    output logic                     ovf,
    output logic                     unf
);
    localparam logic signed [EW-1:0] EXP_MAX = EW'((1 << EXP_W) - 1);
    localparam logic signed [EW-1:0] EXP_MIN = EW'(1);

    logic [FRAC_W:0]       fr;
    logic signed [EW-1:0]  e;

    always_comb begin
        fr = {1'b0, frac_in} + {{FRAC_W{1'b0}}, rnd};
        // A carry out of the fraction leaves an all-zero fraction, i.e. 1.0.
        e  = fr[FRAC_W] ? exp_in + EW'(1) : exp_in;
        ovf  = 1'b0;
        unf  = 1'b0;
        if (e > EXP_MAX) begin
            ovf  = 1'b1;
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
        end else if (e < EXP_MIN) begin
            unf  = 1'b1;
            word = '0;
        end else begin
            word = {sign, e[EXP_W-1:0], fr[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fp_seq_mul.sv
module fp_seq_mul
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [EXP_W+FRAC_W:0]  op_a,
    input  logic [EXP_W+FRAC_W:0]  op_b,
    output logic                   busy,
    output logic                   done,
    output logic [EXP_W+FRAC_W:0]  product,
    output logic                   overflow,
    output logic                   underflow
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int SIG_W = FRAC_W + 1;
    localparam int EW    = EXP_W + 2;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int CNT_W = $clog2(SIG_W);

    fpm_state_e state, state_nx;

    logic                  zero_in, accept;
    logic signed [EW-1:0]  exp_sum;
    logic [FRAC_W-1:0]     frac_a_q;
    logic                  sign_q, zero_q;
    logic signed [EW-1:0]  exp_q, nexp_q, nexp_c;
    logic [CNT_W-1:0]      cnt;
    logic [SIG_W+1:0]      prod_hi;
    logic [FRAC_W-1:0]     nfrac_q, nfrac_c;
    logic                  nrnd_q, nrnd_c;
    logic [W-1:0]          pack_word, product_q;
    logic                  pack_ovf, pack_unf, ovf_q, unf_q;

    assign zero_in = (op_a[W-2 -: EXP_W] == '0) || (op_b[W-2 -: EXP_W] == '0);
    assign accept  = (state == S_IDLE) && start;
    assign exp_sum = $signed({2'b00, op_a[W-2 -: EXP_W]}) + $signed({2'b00, op_b[W-2 -: EXP_W]})
                   - $signed(EW'(BIAS));

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = zero_in ? S_DONE : S_MUL;
            S_MUL:  if (cnt == CNT_W'(SIG_W - 1)) state_nx = S_NORM;
            S_NORM: state_nx = S_RND;
            S_RND:  state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    fpm_sig_mul #(.SIG_W(SIG_W)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (state == S_MUL),
        .mcand   ({1'b1, frac_a_q}),
        .mplier  ({1'b1, op_b[FRAC_W-1:0]}),
        .prod_hi (prod_hi)
    );

    fpm_normalize #(.SIG_W(SIG_W), .EW(EW)) u_norm (
        .prod_hi (prod_hi),
        .exp_in  (exp_q),
        .frac    (nfrac_c),
        .rnd     (nrnd_c),
        .exp_out (nexp_c)
    );

    fpm_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .EW(EW)) u_pack (
        .sign    (sign_q),
        .frac_in (nfrac_q),
        .rnd     (nrnd_q),
        .exp_in  (nexp_q),
        .word    (pack_word),
        .ovf     (pack_ovf),
        .unf     (pack_unf)
    );

    // Datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frac_a_q  <= '0;
            sign_q    <= 1'b0;
            zero_q    <= 1'b0;
            exp_q     <= '0;
            cnt       <= '0;
            nfrac_q   <= '0;
            nrnd_q    <= 1'b0;
            nexp_q    <= '0;
            product_q <= '0;
            ovf_q     <= 1'b0;
            unf_q     <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    frac_a_q <= op_a[FRAC_W-1:0];
                    sign_q   <= op_a[W-1] ^ op_b[W-1];
                    zero_q   <= zero_in;
                    exp_q    <= exp_sum;
                    cnt      <= '0;
                    if (zero_in) begin
                        product_q <= '0;
                        ovf_q     <= 1'b0;
                        unf_q     <= 1'b0;
                    end
                end
                S_MUL:  cnt <= cnt + CNT_W'(1);
                S_NORM: begin
                    nfrac_q <= nfrac_c;
                    nrnd_q  <= nrnd_c;
                    nexp_q  <= nexp_c;
                end
                S_RND: begin
                    product_q <= pack_word;
                    ovf_q     <= pack_ovf;
                    unf_q     <= pack_unf;
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign done      = (state == S_DONE);
    assign product   = product_q;
    assign overflow  = ovf_q;
    assign underflow = unf_q;

    // Assertions
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_hold_ops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(frac_a_q) && $stable(sign_q) && busy));
    p_zero_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero_q) |-> (product == '0 && !overflow && !underflow));
    p_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !zero_q && !underflow) |-> (product[W-1] == sign_q));
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(overflow && underflow));
    p_ovf_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> (&product[W-2:0]));
    p_unf_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && underflow) |-> (product == '0));
    p_mul_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MUL && cnt == CNT_W'(SIG_W - 1)) |=> (state == S_NORM));
endmodule

// File: tb/fp_seq_mul_bench.sv
`timescale 1ns/1ps
module fp_seq_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] op_a = '0, op_b = '0;
    logic        busy, done, overflow, underflow;
    logic [23:0] product;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fp_seq_mul u_fp_seq_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .product(product),
        .overflow(overflow), .underflow(underflow)
    );

    function automatic logic [23:0] mk(input bit s, input int e, input int f);
        return {s, e[7:0], f[14:0]};
    endfunction

    // Behavioural reference: returns {ovf, unf, word}
    function automatic logic [25:0] ref_mul(input logic [23:0] a, input logic [23:0] b);
        longint p, sig;
        int e, r;
        bit s;
        if (a[22:15] == 0 || b[22:15] == 0) return 26'd0;
        s = a[23] ^ b[23];
        p = longint'({1'b1, a[14:0]}) * longint'({1'b1, b[14:0]});
        e = int'(a[22:15]) + int'(b[22:15]) - 127;
        if (p >= 64'h8000_0000) begin
            e++; sig = p >> 16; r = int'((p >> 15) & 1);
        end else begin
            sig = p >> 15; r = int'((p >> 14) & 1);
        end
        sig = sig + r;
        if (sig == 65536) begin sig = 32768; e++; end
        if (e > 255) return {2'b10, s, 8'hFF, 15'h7FFF};
        if (e < 1)   return 26'd0 | (26'd1 << 24);
        return {2'b00, s, e[7:0], sig[14:0]};
    endfunction

    // Cycle-level model
    bit          m_busy = 0;
    int          m_left = 0;
    logic [25:0] m_exp = '0;
    string       m_tag = "R1";
    string       next_tag = "R1";
    bit          run_chk = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0;
        end else if (m_busy) begin
            if (m_left == 0) m_busy = 0;
            else m_left--;
        end else if (start) begin
            m_busy = 1;
            m_exp  = ref_mul(op_a, op_b);
            m_left = (op_a[22:15] == 0 || op_b[22:15] == 0) ? 0 : 18;
            m_tag  = next_tag;
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (run_chk) begin
            bit m_done;
            m_done = m_busy && (m_left == 0);
            chk("R10", "busy", busy, m_busy);
            chk("R11", "done", done, m_done);
            if (m_done) begin
                chk(m_tag, "product", product, m_exp[23:0]);
                chk(m_tag, "overflow (R8)", overflow, m_exp[25]);
                chk(m_tag, "underflow (R9)", underflow, m_exp[24]);
            end
        end
    end

    task automatic run_op(input logic [23:0] a, input logic [23:0] b, input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        next_tag = tag;
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "reset busy", busy, 0);
        chk("R11", "reset done", done, 0);
        chk("R2", "reset product", product, 0);
        run_chk = 1;

        run_op(mk(0,127,0),      mk(0,127,0),      "R1");   // 1.0*1.0
        run_op(mk(0,130,16'h2A5), mk(0,120,16'h1234), "R4");
        run_op(mk(0,127,16'h4000), mk(0,127,16'h4000), "R5"); // 1.5*1.5
        run_op(mk(1,128,0),      mk(0,128,16'h4000), "R3"); // -2*3
        run_op(mk(1,125,16'h7FFF), mk(1,131,16'h3001), "R3");
        run_op(mk(0,127,16'h0003), mk(0,127,16'h4001), "R6");
        run_op(mk(0,140,16'h5555), mk(0,101,16'h2AAB), "R6");
        run_op(mk(0,127,16'h0001), mk(0,127,16'h7FFE), "R7"); // rounds up to 2.0
        run_op(mk(0,0,16'h1234), mk(0,150,16'h4000), "R2");
        run_op(mk(1,140,16'h0100), mk(1,0,0),        "R2");
        run_op(mk(0,200,0),      mk(1,200,0),      "R8");
        run_op(mk(0,127,0),      mk(0,255,0),      "R8");   // exactly 255
        run_op(mk(0,127,16'h4000), mk(0,255,16'h4000), "R8"); // 256
        run_op(mk(0,10,0),       mk(0,10,0),       "R9");
        run_op(mk(0,64,0),       mk(0,64,0),       "R9");   // exactly 1
        run_op(mk(0,63,0),       mk(0,64,0),       "R9");   // 0

        // R11: start during busy is ignored
        @(negedge clk);
        next_tag = "R11";
        op_a = mk(0,127,16'h4000); op_b = mk(0,128,16'h2000); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        op_a = mk(1,200,16'h7777); op_b = mk(1,0,0); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);

        // R10: back-to-back operations
        run_op(mk(1,100,16'h0F0F), mk(0,160,16'h7001), "R10");
        run_op(mk(0,126,16'h7FFF), mk(0,126,16'h7FFF), "R10");

        run_chk = 0;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end
endmodule